// File: doc/BRIEF.md
# Wave Divergence Mask Stack

This block keeps the per-lane active mask of every resident SIMT wave while that wave runs structured control flow. Each cycle it accepts at most one decoded control-flow operation. The operation carries a wave index, an operation code, a per-lane predicate vector and a negate bit. The block updates that wave's active mask and its nesting stack. In the same cycle it tells the sequencer whether the enclosing loop must jump back to its head, and whether the path just opened has no live lanes and can be bypassed.

Each stack entry is either a conditional or a loop. A conditional entry remembers the mask in force before the `if` and the set of lanes that took the then-path. A loop entry remembers the mask in force before the loop, the lanes that have left it through `break`, and the lanes parked by `continue` until the iteration ends. Lanes that leave a loop from inside a nested conditional are kept out when that conditional closes. Every wave owns its stack, its innermost-loop pointer and a sticky overflow flag.

Top module: `wave_mask_stack`

## Requirements
- R1: After a synchronous active-low reset, every wave has all lanes active, an empty stack and a clear overflow flag.
- R2: The lane condition is the predicate inverted on every lane when `op_neg` is 1. An `if` (op_code 0) pushes a conditional entry and leaves active only the lanes that were active and whose condition is 1.
- R3: An `else` (op_code 1) makes active the lanes that were active at the matching `if`, were not on the then-path and have not left the innermost loop.
- R4: An `endif` (op_code 2) pops the conditional entry and restores the mask from before the `if`, minus lanes that left the innermost enclosing loop through `break` or `continue`.
- R5: A `break` (op_code 4) deactivates the active lanes whose condition is 1 and keeps them out of the innermost loop for all later iterations. A lane never gains activity from a `break`.
- R6: A `continue` (op_code 5) deactivates the active lanes whose condition is 1 until the end of the current iteration. They are active again after the next `endloop` that branches back.
- R7: An `endloop` (op_code 6) raises `branch_back` in the same cycle when some lane of the loop has not broken out. The mask then becomes those lanes. Otherwise the loop entry is popped and the mask from before `loop` (op_code 3) is restored. `branch_back` is raised for no other operation.
- R8: Any mix of conditionals and loops nests up to DEPTH levels (default 32), and unwinds to the original mask.
- R9: `skip_hint` is raised in the same cycle as an `if` or `else` whose resulting mask is all zero. It is raised for no other case.
- R10: An `if` or `loop` issued while the wave's stack holds DEPTH entries sets that wave's sticky overflow flag and leaves its mask and stack unchanged. `overflow` shows the flag of the selected wave.
- R11: An operation touches only the wave named by `op_wave`. An index at or above WAVES changes no wave and drives all outputs to zero.
- R12: `active_mask` shows the selected wave's mask before this cycle's operation. The following have no effect: op_code 7; `else`, `endif` or `endloop` when the top entry is missing or of the other kind; `break` or `continue` outside any loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_wave | input | $clog2(WAVES) | Wave the operation (and the outputs) refer to |
| op_code | input | 3 | 0 if, 1 else, 2 endif, 3 loop, 4 break, 5 continue, 6 endloop, 7 none |
| op_pred | input | LANES | Per-lane predicate |
| op_neg | input | 1 | Invert the predicate on every lane |
| active_mask | output | LANES | Selected wave's mask before this cycle's operation |
| branch_back | output | 1 | Loop must return to its head |
| skip_hint | output | 1 | Path just opened has no active lane |
| overflow | output | 1 | Selected wave's sticky overflow flag |

## Verification
The bench builds the block with 8 lanes, the default depth of 32 and three waves. With three waves the 2-bit wave index has one value, 3, that names no wave, so the out-of-range case can be reached. With the full default depth, the bench nests 32 mixed entries, then drives the stack past its limit with both kinds of push, then unwinds. A behavioural model with one queue per wave predicts every output on every cycle. The model covers directed loop, break, continue and else cases, malformed sequences, and a long random stream across all wave indices.

// File: rtl/wms_pkg.sv
// Shared definitions for the wave divergence mask stack.
// Assumes a 3-bit operation code supplied by the decoder.
package wms_pkg;
    typedef enum logic [2:0] {
        OP_IF      = 3'd0,
        OP_ELSE    = 3'd1,
        OP_ENDIF   = 3'd2,
        OP_LOOP    = 3'd3,
        OP_BREAK   = 3'd4,
        OP_CONT    = 3'd5,
        OP_ENDLOOP = 3'd6,
        OP_NONE    = 3'd7
    } wms_op_e;
endpackage

// File: rtl/wms_lane_select.sv
// Per-lane condition former: applies the optional negation to the
// predicate before any lane selection. Purely combinational.
module wms_lane_select #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] pred,
    input  logic             neg,
    output logic [LANES-1:0] cond
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // one lane: invert the predicate when negation is requested
        assign cond[l] = pred[l] ^ neg;
    end
endmodule

// File: rtl/wms_wave_ctx.sv
// Control-flow context of one wave: active mask, nesting stack,
// innermost-loop pointer and sticky overflow flag.
// Assumes at most one operation per cycle, gated by en.
// Stack entries are only read while they are valid, so the storage
// arrays carry no reset.
module wms_wave_ctx
    import wms_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  wms_op_e          op,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] mask_o,
    output logic             ovf_o,
    output logic             branch_o,
    output logic             skip_o
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH + 1);

    logic [LANES-1:0] mask_q;
    logic [SPW-1:0]   sp_q;
    logic [PW-1:0]    lp_q;
    logic             lpv_q;
    logic             ovf_q;

    logic             kind_q  [DEPTH];   // 1 = loop entry
    logic [LANES-1:0] saved_q [DEPTH];
    logic [LANES-1:0] xa_q    [DEPTH];   // then-lanes or broken lanes
    logic [LANES-1:0] yb_q    [DEPTH];   // continued lanes
    logic [PW-1:0]    oidx_q  [DEPTH];   // enclosing loop pointer
    logic             ovld_q  [DEPTH];

    logic             empty, full;
    logic [PW-1:0]    top, push_idx;
    logic [LANES-1:0] sel, gone, remain, else_mask, mask_n;
    logic             do_push, push_loop, do_pop, set_ovf;
    logic             brk_wr, cnt_wr, clr_cnt, branch, skip;

    // stack position and lanes that have left the innermost loop
    always_comb begin
        empty    = (sp_q == '0);
        full     = (sp_q == SPW'(DEPTH));
        top      = PW'(sp_q - 1'b1);
        push_idx = PW'(sp_q);
        sel      = mask_q & cond;
        gone     = lpv_q ? (xa_q[lp_q] | yb_q[lp_q]) : '0;
        remain   = saved_q[top] & ~xa_q[top];
        else_mask = saved_q[top] & ~xa_q[top] & ~gone;
    end

    // next mask and stack actions for the presented operation
    always_comb begin
        mask_n    = mask_q;
        do_push   = 1'b0;
        push_loop = 1'b0;
        do_pop    = 1'b0;
        set_ovf   = 1'b0;
        brk_wr    = 1'b0;
        cnt_wr    = 1'b0;
        clr_cnt   = 1'b0;
        branch    = 1'b0;
        skip      = 1'b0;
        case (op)
            OP_IF: begin
                if (full) begin
                    set_ovf = 1'b1;
                end else begin
                    do_push = 1'b1;
                    mask_n  = sel;
                    skip    = (sel == '0);
                end
            end
            OP_ELSE: begin
                if (!empty && !kind_q[top]) begin
                    mask_n = else_mask;
                    skip   = (else_mask == '0);
                end
            end
            OP_ENDIF: begin
                if (!empty && !kind_q[top]) begin
                    mask_n = saved_q[top] & ~gone;
                    do_pop = 1'b1;
                end
            end
            OP_LOOP: begin
                if (full) begin
                    set_ovf = 1'b1;
                end else begin
                    do_push   = 1'b1;
                    push_loop = 1'b1;
                end
            end
            OP_BREAK: begin
                if (lpv_q) begin
                    brk_wr = 1'b1;
                    mask_n = mask_q & ~sel;
                end
            end
            OP_CONT: begin
                if (lpv_q) begin
                    cnt_wr = 1'b1;
                    mask_n = mask_q & ~sel;
                end
            end
            OP_ENDLOOP: begin
                if (!empty && kind_q[top]) begin
                    if (remain != '0) begin
                        branch  = 1'b1;
                        clr_cnt = 1'b1;
                        mask_n  = remain;
                    end else begin
                        do_pop = 1'b1;
                        mask_n = saved_q[top];
                    end
                end
            end
            default: ;
        endcase
    end

    // architectural state: mask, stack pointer, loop pointer, overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            sp_q   <= '0;
            lp_q   <= '0;
            lpv_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (en) begin
            mask_q <= mask_n;
            if (set_ovf) ovf_q <= 1'b1;
            if (do_push) begin
                sp_q <= sp_q + 1'b1;
                if (push_loop) begin
                    lp_q  <= push_idx;
                    lpv_q <= 1'b1;
                end
            end
            if (do_pop) begin
                sp_q <= sp_q - 1'b1;
                if (kind_q[top]) begin
                    lp_q  <= oidx_q[top];
                    lpv_q <= ovld_q[top];
                end
            end
        end
    end

    // stack entry storage: push, exit-mask updates, continue clear
    always_ff @(posedge clk) begin
        if (rst_n && en) begin
            if (do_push) begin
                kind_q[push_idx]  <= push_loop;
                saved_q[push_idx] <= mask_q;
                xa_q[push_idx]    <= push_loop ? '0 : sel;
                yb_q[push_idx]    <= '0;
                oidx_q[push_idx]  <= lp_q;
                ovld_q[push_idx]  <= lpv_q;
            end
            if (brk_wr) xa_q[lp_q] <= xa_q[lp_q] | sel;
            if (cnt_wr) yb_q[lp_q] <= yb_q[lp_q] | sel;
            if (clr_cnt) yb_q[top] <= '0;
        end
    end

    assign mask_o   = mask_q;
    assign ovf_o    = ovf_q;
    assign branch_o = en & branch;
    assign skip_o   = en & skip;
endmodule

// File: rtl/wave_mask_stack.sv
// Top of the wave divergence mask stack: one context per resident
// wave, a shared condition former, and an output selector keyed by
// op_wave. Assumes one operation per cycle; an out-of-range wave
// index enables no context and reads back zeros.
module wave_mask_stack
    import wms_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 32,
    parameter int WAVES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  op_valid,
    input  logic [((WAVES>1)?$clog2(WAVES):1)-1:0] op_wave,
    input  logic [2:0]                            op_code,
    input  logic [LANES-1:0]                      op_pred,
    input  logic                                  op_neg,
    output logic [LANES-1:0]                      active_mask,
    output logic                                  branch_back,
    output logic                                  skip_hint,
    output logic                                  overflow
);
    localparam int WIDW = (WAVES > 1) ? $clog2(WAVES) : 1;

    logic [LANES-1:0] cond;
    logic [LANES-1:0] w_mask   [WAVES];
    logic             w_ovf    [WAVES];
    logic             w_branch [WAVES];
    logic             w_skip   [WAVES];

    wms_lane_select #(.LANES(LANES)) u_sel (
        .pred (op_pred),
        .neg  (op_neg),
        .cond (cond)
    );

    for (genvar g = 0; g < WAVES; g++) begin : g_wave
        logic en;
        assign en = op_valid && (op_wave == WIDW'(g));
        wms_wave_ctx #(.LANES(LANES), .DEPTH(DEPTH)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .op       (wms_op_e'(op_code)),
            .cond     (cond),
            .mask_o   (w_mask[g]),
            .ovf_o    (w_ovf[g]),
            .branch_o (w_branch[g]),
            .skip_o   (w_skip[g])
        );
    end

    // present the selected wave's outputs, zeros for an unknown index
    always_comb begin
        active_mask = '0;
        overflow    = 1'b0;
        branch_back = 1'b0;
        skip_hint   = 1'b0;
        for (int i = 0; i < WAVES; i++) begin
            if (op_wave == WIDW'(i)) begin
                active_mask = w_mask[i];
                overflow    = w_ovf[i];
                branch_back = w_branch[i];
                skip_hint   = w_skip[i];
            end
        end
    end
endmodule

// File: rtl/wms_checker.sv
// Port-level temporal checks for wave_mask_stack, attached by bind.
module wms_checker #(
    parameter int LANES = 8,
    parameter int WAVES = 4
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  op_valid,
    input logic [((WAVES>1)?$clog2(WAVES):1)-1:0] op_wave,
    input logic [2:0]                            op_code,
    input logic [LANES-1:0]                      active_mask,
    input logic                                  branch_back,
    input logic                                  skip_hint,
    input logic                                  overflow
);
    assert_branch_only_endloop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_back |-> (op_valid && op_code == 3'd6));

    assert_skip_only_if_else_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip_hint |-> (op_valid && (op_code == 3'd0 || op_code == 3'd1)));

    assert_skip_leaves_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid && op_code == 3'd0 && skip_hint)
         && op_wave == $past(op_wave)) |-> (active_mask == '0));

    assert_no_overflow_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(overflow) && op_wave == $past(op_wave)) |-> overflow);

    assert_idle_keeps_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid) && op_wave == $past(op_wave))
        |-> $stable(active_mask));

    assert_break_no_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid && op_code == 3'd4) && op_wave == $past(op_wave))
        |-> ((active_mask & ~$past(active_mask)) == '0));
endmodule

bind wave_mask_stack wms_checker #(.LANES(LANES), .WAVES(WAVES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_wave     (op_wave),
    .op_code     (op_code),
    .active_mask (active_mask),
    .branch_back (branch_back),
    .skip_hint   (skip_hint),
    .overflow    (overflow)
);

// File: tb/wave_mask_stack_bench.sv
`timescale 1ns/1ps
module wave_mask_stack_bench;
    localparam int LN = 8;
    localparam int DP = 32;
    localparam int NW = 3;

    typedef struct {
        bit       is_loop;
        bit [7:0] saved;
        bit [7:0] x;
        bit [7:0] y;
    } ent_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_wave = '0;
    logic [2:0]    op_code = 3'd7;
    logic [LN-1:0] op_pred = '0;
    logic          op_neg = 1'b0;
    logic [LN-1:0] active_mask;
    logic          branch_back, skip_hint, overflow;

    int nchecks = 0;
    int nfail = 0;

    bit [7:0] m_mask [NW];
    bit       m_ovf  [NW];
    ent_t     m_stk  [NW][$];

    always #10 clk = ~clk;

    wave_mask_stack #(.LANES(LN), .DEPTH(DP), .WAVES(NW)) u_wave_mask_stack (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_wave(op_wave),
        .op_code(op_code), .op_pred(op_pred), .op_neg(op_neg),
        .active_mask(active_mask), .branch_back(branch_back),
        .skip_hint(skip_hint), .overflow(overflow)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: returns pre-op outputs, then advances state
    task automatic model(input int w, input int code, input bit [7:0] pred, input bit neg, input bit vld,
                         output bit [7:0] e_mask, output bit e_ovf, output bit e_br, output bit e_skip);
        bit [7:0] c, gone, sel, rem;
        int li, n;
        ent_t e;
        e_mask = '0; e_ovf = 0; e_br = 0; e_skip = 0;
        if (w >= NW) return;
        e_mask = m_mask[w];
        e_ovf  = m_ovf[w];
        if (!vld) return;
        c = neg ? ~pred : pred;
        sel = m_mask[w] & c;
        n = m_stk[w].size();
        li = -1;
        for (int k = n - 1; k >= 0; k--) begin
            if (m_stk[w][k].is_loop) begin li = k; break; end
        end
        gone = (li >= 0) ? (m_stk[w][li].x | m_stk[w][li].y) : 8'h00;
        case (code)
            0: if (n == DP) m_ovf[w] = 1;
               else begin
                   e = '{0, m_mask[w], sel, 8'h00};
                   m_stk[w].push_back(e);
                   m_mask[w] = sel;
                   e_skip = (sel == 0);
               end
            1: if (n > 0 && !m_stk[w][n-1].is_loop) begin
                   e = m_stk[w][n-1];
                   m_mask[w] = e.saved & ~e.x & ~gone;
                   e_skip = (m_mask[w] == 0);
               end
            2: if (n > 0 && !m_stk[w][n-1].is_loop) begin
                   e = m_stk[w][n-1];
                   m_mask[w] = e.saved & ~gone;
                   void'(m_stk[w].pop_back());
               end
            3: if (n == DP) m_ovf[w] = 1;
               else begin
                   e = '{1, m_mask[w], 8'h00, 8'h00};
                   m_stk[w].push_back(e);
               end
            4, 5: if (li >= 0) begin
                   e = m_stk[w][li];
                   if (code == 4) e.x = e.x | sel; else e.y = e.y | sel;
                   m_stk[w][li] = e;
                   m_mask[w] = m_mask[w] & ~sel;
               end
            6: if (n > 0 && m_stk[w][n-1].is_loop) begin
                   e = m_stk[w][n-1];
                   rem = e.saved & ~e.x;
                   if (rem != 0) begin
                       e_br = 1;
                       m_mask[w] = rem;
                       e.y = 8'h00;
                       m_stk[w][n-1] = e;
                   end else begin
                       m_mask[w] = e.saved;
                       void'(m_stk[w].pop_back());
                   end
               end
            default: ;
        endcase
    endtask

    // drive one cycle, compare all outputs against the model mid-cycle
    task automatic step(input int w, input int code, input bit [7:0] pred, input bit neg,
                        input bit vld, input string req);
        bit [7:0] e_mask;
        bit e_ovf, e_br, e_skip;
        @(negedge clk);
        op_valid = vld; op_wave = w[1:0]; op_code = code[2:0];
        op_pred = pred; op_neg = neg;
        model(w, code, pred, neg, vld, e_mask, e_ovf, e_br, e_skip);
        #2;
        chk(req, "active_mask", 32'(active_mask), 32'(e_mask));
        chk(req, "overflow", 32'(overflow), 32'(e_ovf));
        chk(req, "branch_back", 32'(branch_back), 32'(e_br));
        chk(req, "skip_hint", 32'(skip_hint), 32'(e_skip));
        @(posedge clk);
    endtask

    task automatic peek(input int w, input string req);
        step(w, 7, 8'h00, 1'b0, 1'b0, req);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int kinds [DP];
        for (int w = 0; w < NW; w++) begin
            m_mask[w] = 8'hFF; m_ovf[w] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every wave
        for (int w = 0; w < NW; w++) peek(w, "R1");

        // R2 R3 R4: plain if / else / endif, with and without negation
        step(0, 0, 8'h0F, 0, 1, "R2");
        step(0, 1, 8'h00, 0, 1, "R3");
        step(0, 2, 8'h00, 0, 1, "R4");
        peek(0, "R4");
        step(0, 0, 8'h0F, 1, 1, "R2");
        step(0, 0, 8'h30, 0, 1, "R2");
        step(0, 1, 8'h00, 0, 1, "R3");
        step(0, 2, 8'h00, 0, 1, "R4");
        step(0, 1, 8'h00, 0, 1, "R3");
        step(0, 2, 8'h00, 0, 1, "R4");
        peek(0, "R4");

        // R9: empty then-path and full else-path
        step(0, 0, 8'h00, 0, 1, "R9");
        step(0, 1, 8'h00, 0, 1, "R9");
        step(0, 2, 8'h00, 0, 1, "R9");
        step(0, 0, 8'hFF, 1, 1, "R9");
        step(0, 2, 8'h00, 0, 1, "R9");

        // R5 R6 R7: loop with break, continue, negated break, exit
        step(1, 3, 8'h00, 0, 1, "R7");
        step(1, 4, 8'h01, 0, 1, "R5");
        step(1, 5, 8'h02, 0, 1, "R6");
        step(1, 6, 8'h00, 0, 1, "R7");
        step(1, 4, 8'hFF, 1, 1, "R5");
        step(1, 4, 8'h0F, 1, 1, "R5");
        step(1, 6, 8'h00, 0, 1, "R7");
        step(1, 4, 8'hFF, 0, 1, "R5");
        step(1, 6, 8'h00, 0, 1, "R7");
        peek(1, "R7");

        // R4 R3: break and continue inside conditionals inside a loop
        step(2, 3, 8'h00, 0, 1, "R4");
        step(2, 0, 8'h33, 0, 1, "R4");
        step(2, 4, 8'h01, 0, 1, "R5");
        step(2, 2, 8'h00, 0, 1, "R4");
        step(2, 0, 8'h0F, 0, 1, "R3");
        step(2, 5, 8'h02, 0, 1, "R6");
        step(2, 1, 8'h00, 0, 1, "R3");
        step(2, 2, 8'h00, 0, 1, "R4");
        step(2, 6, 8'h00, 0, 1, "R6");
        step(2, 4, 8'hFF, 0, 1, "R7");
        step(2, 6, 8'h00, 0, 1, "R7");

        // R7: nested loops restore the outer mask on inner exit
        step(0, 3, 8'h00, 0, 1, "R7");
        step(0, 3, 8'h00, 0, 1, "R7");
        step(0, 4, 8'h80, 0, 1, "R5");
        step(0, 6, 8'h00, 0, 1, "R7");
        step(0, 4, 8'hFF, 0, 1, "R5");
        step(0, 6, 8'h00, 0, 1, "R7");
        step(0, 4, 8'h01, 0, 1, "R5");
        step(0, 6, 8'h00, 0, 1, "R7");
        step(0, 4, 8'hFF, 0, 1, "R5");
        step(0, 6, 8'h00, 0, 1, "R7");
        peek(0, "R7");

        // R11: isolation between waves and an unknown wave index
        step(1, 0, 8'h00, 0, 1, "R11");
        peek(0, "R11");
        peek(2, "R11");
        step(3, 0, 8'h00, 0, 1, "R11");
        step(3, 3, 8'h00, 0, 1, "R11");
        for (int w = 0; w < NW; w++) peek(w, "R11");
        step(1, 2, 8'h00, 0, 1, "R11");

        // R12: malformed or empty operations change nothing
        step(2, 2, 8'h00, 0, 1, "R12");
        step(2, 1, 8'h00, 0, 1, "R12");
        step(2, 4, 8'hFF, 0, 1, "R12");
        step(2, 5, 8'hFF, 0, 1, "R12");
        step(2, 6, 8'h00, 0, 1, "R12");
        step(2, 7, 8'hFF, 0, 1, "R12");
        step(2, 3, 8'h00, 0, 1, "R12");
        step(2, 2, 8'h00, 0, 1, "R12");
        step(2, 1, 8'h00, 0, 1, "R12");
        step(2, 4, 8'hFF, 0, 1, "R12");
        step(2, 6, 8'h00, 0, 1, "R12");
        peek(2, "R12");

        // R8: full-depth mixed nesting, then R10 overflow, then unwind
        for (int k = 0; k < DP; k++) begin
            kinds[k] = (k % 3 == 2) ? 1 : 0;
            if (kinds[k] == 1) step(2, 3, 8'h00, 0, 1, "R8");
            else step(2, 0, 8'hFF ^ (8'h01 << (k % 8)), 0, 1, "R8");
        end
        step(2, 0, 8'hFF, 0, 1, "R10");
        step(2, 3, 8'h00, 0, 1, "R10");
        peek(2, "R10");
        for (int k = DP - 1; k >= 0; k--) begin
            if (kinds[k] == 1) begin
                step(2, 4, 8'hFF, 0, 1, "R8");
                step(2, 6, 8'h00, 0, 1, "R8");
            end else begin
                step(2, 2, 8'h00, 0, 1, "R8");
            end
        end
        peek(2, "R10");
        peek(0, "R11");
        peek(1, "R11");

        // R12: random stream over all wave indices
        for (int i = 0; i < 600; i++) begin
            step(int'($urandom % 4), int'($urandom % 8), 8'($urandom),
                 1'($urandom), 1'($urandom % 5 != 0), "R12");
        end
        for (int w = 0; w < 4; w++) peek(w, "R12");

        finish_run();
    end
endmodule